// File: doc/BRIEF.md
# Balanced Ternary Digit ALU

This block performs one operation on a pair of balanced-ternary digits (trits) and is purely combinational. Each trit travels on a two-bit wire: 2'b01 stands for -1, 2'b10 for +1 and 2'b11 for 0. The remaining code, 2'b00, marks a broken or undriven wire. On an input it is read as the value 0, and the block never drives it onto an output.

A two-bit select picks the operation: 0 adds, 1 multiplies, 2 negates and 3 forms the consensus of the operands. Addition produces a result digit and a carry digit. Every other operation holds the carry at zero. The block is meant to be placed inside a wider datapath, so any chaining of carries across several digits is left to the logic around it.

Top module: `trit_alu`

## Requirements
- R1: Outputs use the codes 2'b01 for -1, 2'b10 for +1 and 2'b11 for 0, and never show 2'b00 for any input or select value.
- R2: An input carrying 2'b00 behaves exactly as an input carrying 2'b11 (value 0) under every operation.
- R3: With select 0 (add) the integer sum s of a and b decides the outputs. s = +2 gives result -1 and carry +1. s = -2 gives result +1 and carry -1. s in {-1, 0, +1} gives result s and carry 0.
- R4: With select 1 (multiply) the result is 0 when either operand is 0. Otherwise it is +1 when the operands are equal and -1 when they differ.
- R5: With select 2 (negate) the result is -a: +1 and -1 exchange and 0 stays 0. Operand b has no effect on either output.
- R6: With select 3 (consensus) the result equals a when a and b have the same value, and 0 otherwise.
- R7: For selects 1, 2 and 3 the carry output is 2'b11 (zero).
- R8: Adding +1 to +1 and then feeding the resulting result and carry back into the add operation gives result 0 and carry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation: 0 add, 1 multiply, 2 negate, 3 consensus |
| a_trit | input | 2 | First operand trit, wire-coded |
| b_trit | input | 2 | Second operand trit, wire-coded |
| res_trit | output | 2 | Result trit, wire-coded |
| carry_trit | output | 2 | Carry trit, wire-coded; zero except for add |

## Verification
The block holds no register, so both outputs are due in the same cycle as the operands and select that produce them. The bench changes inputs on the falling clock edge and samples one time unit later, after the combinational paths have settled and well away from the rising edge. The expected outputs come from the integer values of the operands. Every combination of select and input codes, fault codes included, is applied once, followed by seeded random patterns and a directed carry feedback sequence.

// File: rtl/trit_alu_pkg.sv
package trit_alu_pkg;

    localparam int TRIT_W = 2;

    localparam logic [TRIT_W-1:0] T_FAULT = 2'b00;
    localparam logic [TRIT_W-1:0] T_NEG   = 2'b01;
    localparam logic [TRIT_W-1:0] T_POS   = 2'b10;
    localparam logic [TRIT_W-1:0] T_ZERO  = 2'b11;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_MUL  = 2'd1,
        OP_NEG  = 2'd2,
        OP_CONS = 2'd3
    } trit_op_e;

    typedef struct packed {
        logic [TRIT_W-1:0] res;
        logic [TRIT_W-1:0] carry;
    } trit_pair_t;

    // Integer view of a wire code; the fault code reads as zero.
    function automatic int trit_val(logic [TRIT_W-1:0] code);
        case (code)
            T_NEG:   return -1;
            T_POS:   return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/trit_clean.sv
module trit_clean
    import trit_alu_pkg::*;
(
    input  logic [TRIT_W-1:0] raw_d,
    output logic [TRIT_W-1:0] clean_d
);

    // Map the fault code onto zero so that later stages see three codes only.
    always_comb begin
        clean_d = (raw_d == T_FAULT) ? T_ZERO : raw_d;
    end

endmodule

// File: rtl/trit_adder.sv
module trit_adder
    import trit_alu_pkg::*;
(
    input  logic [TRIT_W-1:0] a_d,
    input  logic [TRIT_W-1:0] b_d,
    output trit_pair_t        sum_d
);

    logic both_pos;
    logic both_neg;
    logic a_zero;
    logic b_zero;

    always_comb begin
        both_pos = (a_d == T_POS) && (b_d == T_POS);
        both_neg = (a_d == T_NEG) && (b_d == T_NEG);
        a_zero   = (a_d == T_ZERO);
        b_zero   = (b_d == T_ZERO);

        sum_d.carry = T_ZERO;
        if (both_pos) begin
            sum_d.res   = T_NEG;
            sum_d.carry = T_POS;
        end else if (both_neg) begin
            sum_d.res   = T_POS;
            sum_d.carry = T_NEG;
        end else if (a_zero) begin
            sum_d.res = b_d;
        end else if (b_zero) begin
            sum_d.res = a_d;
        end else begin
            // opposite signs cancel
            sum_d.res = T_ZERO;
        end
    end

endmodule

// File: rtl/trit_logic.sv
module trit_logic
    import trit_alu_pkg::*;
(
    input  logic [TRIT_W-1:0] a_d,
    input  logic [TRIT_W-1:0] b_d,
    output logic [TRIT_W-1:0] mul_d,
    output logic [TRIT_W-1:0] neg_d,
    output logic [TRIT_W-1:0] cons_d
);

    always_comb begin
        // Swapping the two wire bits negates; zero (11) maps to itself.
        neg_d = {a_d[0], a_d[1]};

        if ((a_d == T_ZERO) || (b_d == T_ZERO)) begin
            mul_d = T_ZERO;
        end else if (a_d == b_d) begin
            mul_d = T_POS;
        end else begin
            mul_d = T_NEG;
        end

        cons_d = (a_d == b_d) ? a_d : T_ZERO;
    end

endmodule

// File: rtl/trit_alu.sv
module trit_alu
    import trit_alu_pkg::*;
(
    input  logic [1:0]        op_sel,
    input  logic [TRIT_W-1:0] a_trit,
    input  logic [TRIT_W-1:0] b_trit,
    output logic [TRIT_W-1:0] res_trit,
    output logic [TRIT_W-1:0] carry_trit
);

    localparam int N_OPND = 2;

    logic [TRIT_W-1:0] raw_d   [N_OPND];
    logic [TRIT_W-1:0] clean_d [N_OPND];

    assign raw_d[0] = a_trit;
    assign raw_d[1] = b_trit;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_clean
        trit_clean u_clean (
            .raw_d   (raw_d[gi]),
            .clean_d (clean_d[gi])
        );
    end

    trit_pair_t        sum_d;
    logic [TRIT_W-1:0] mul_d;
    logic [TRIT_W-1:0] neg_d;
    logic [TRIT_W-1:0] cons_d;
    trit_pair_t        out_d;

    trit_adder u_adder (
        .a_d   (clean_d[0]),
        .b_d   (clean_d[1]),
        .sum_d (sum_d)
    );

    trit_logic u_logic (
        .a_d    (clean_d[0]),
        .b_d    (clean_d[1]),
        .mul_d  (mul_d),
        .neg_d  (neg_d),
        .cons_d (cons_d)
    );

    always_comb begin
        out_d.carry = T_ZERO;
        case (trit_op_e'(op_sel))
            OP_ADD:  out_d   = sum_d;
            OP_MUL:  out_d.res = mul_d;
            OP_NEG:  out_d.res = neg_d;
            default: out_d.res = cons_d;
        endcase
    end

    assign res_trit   = out_d.res;
    assign carry_trit = out_d.carry;

    // Checks on the selected outputs against the operand values.
    always_comb begin
        a_r1_no_fault_res: assert (res_trit != T_FAULT);
        a_r1_no_fault_carry: assert (carry_trit != T_FAULT);
        if (trit_op_e'(op_sel) != OP_ADD) begin
            a_r7_carry_zero: assert (carry_trit == T_ZERO);
        end
        if (trit_op_e'(op_sel) == OP_ADD) begin
            // R3: result plus three times carry equals the integer sum
            a_r3_sum_value: assert (trit_val(res_trit) + 3 * trit_val(carry_trit)
                                    == trit_val(a_trit) + trit_val(b_trit));
        end
        if (trit_op_e'(op_sel) == OP_NEG) begin
            a_r5_neg_value: assert (trit_val(res_trit) + trit_val(a_trit) == 0);
        end
    end

endmodule

// File: tb/trit_alu_bench.sv
module trit_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic [1:0] a_trit = 2'b00;
    logic [1:0] b_trit = 2'b00;
    logic [1:0] res_trit;
    logic [1:0] carry_trit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trit_alu u_trit_alu (
        .op_sel     (op_sel),
        .a_trit     (a_trit),
        .b_trit     (b_trit),
        .res_trit   (res_trit),
        .carry_trit (carry_trit)
    );

    function automatic int val_of(logic [1:0] c);
        if (c == 2'b01) return -1;
        if (c == 2'b10) return 1;
        return 0;
    endfunction

    function automatic logic [1:0] code_of(int v);
        if (v < 0) return 2'b01;
        if (v > 0) return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [3:0] expect_pair(logic [1:0] op, logic [1:0] a, logic [1:0] b);
        int va = val_of(a);
        int vb = val_of(b);
        int s;
        case (op)
            2'd0: begin
                s = va + vb;
                if (s == 2) return {code_of(-1), code_of(1)};
                if (s == -2) return {code_of(1), code_of(-1)};
                return {code_of(s), code_of(0)};
            end
            2'd1: return {code_of(va * vb), code_of(0)};
            2'd2: return {code_of(-va), code_of(0)};
            default: return {code_of((va == vb) ? va : 0), code_of(0)};
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] op, logic [1:0] a, logic [1:0] b);
        if (a == 2'b00 || b == 2'b00) return "R2";
        case (op)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_val(string tag, logic [1:0] got, logic [1:0] want, string what);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b (op=%0d a=%b b=%b)",
                     tag, what, got, want, op_sel, a_trit, b_trit);
        end
    endtask

    task automatic apply(logic [1:0] op, logic [1:0] a, logic [1:0] b);
        @(negedge clk);
        op_sel = op;
        a_trit = a;
        b_trit = b;
        #1;
    endtask

    task automatic run_one(logic [1:0] op, logic [1:0] a, logic [1:0] b);
        logic [3:0] e;
        string t;
        apply(op, a, b);
        e = expect_pair(op, a, b);
        t = tag_of(op, a, b);
        check_val(t, res_trit, e[3:2], "result");
        if (op == 2'd0) check_val(t, carry_trit, e[1:0], "carry");
        else check_val("R7", carry_trit, e[1:0], "carry");
        if (res_trit == 2'b00 || carry_trit == 2'b00) begin
            check_val("R1", 2'b00, 2'b11, "fault code on output");
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [1:0] r0;
        logic [1:0] c0;
        logic [1:0] negref;
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: all inputs at the fault code, add selected (R1, R2)
        #1;
        check_val("R1", res_trit, 2'b11, "reset result");
        check_val("R2", carry_trit, 2'b11, "reset carry");

        // Exhaustive sweep of select and codes (R1..R7)
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    run_one(op[1:0], a[1:0], b[1:0]);

        // R5: negate ignores b, compared across all b for each a
        for (int a = 0; a < 4; a++) begin
            apply(2'd2, a[1:0], 2'b11);
            negref = res_trit;
            for (int b = 0; b < 4; b++) begin
                apply(2'd2, a[1:0], b[1:0]);
                check_val("R5", res_trit, negref, "negate result with varied b");
                check_val("R5", carry_trit, 2'b11, "negate carry with varied b");
            end
        end

        // R2: fault input equals zero input under each operation
        for (int op = 0; op < 4; op++) begin
            apply(op[1:0], 2'b10, 2'b11);
            r0 = res_trit;
            c0 = carry_trit;
            apply(op[1:0], 2'b10, 2'b00);
            check_val("R2", res_trit, r0, "fault b result");
            check_val("R2", carry_trit, c0, "fault b carry");
        end

        // R8: carry feedback of +1 + +1
        apply(2'd0, 2'b10, 2'b10);
        check_val("R8", res_trit, 2'b01, "first sum");
        check_val("R8", carry_trit, 2'b10, "first carry");
        r0 = res_trit;
        c0 = carry_trit;
        apply(2'd0, r0, c0);
        check_val("R8", res_trit, 2'b11, "fed-back sum");
        check_val("R8", carry_trit, 2'b11, "fed-back carry");

        // Seeded random patterns
        for (int i = 0; i < 400; i++) begin
            run_one(2'($urandom), 2'($urandom), 2'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule